// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic core of a small 8-bit controller. A combinational datapath takes an opcode, the accumulator operand `acc_in` and a second operand `opnd_in` (a memory or immediate value). It returns the result and a skip-condition signal in the same cycle. Alongside it sits a clocked status register holding carry, half carry, zero and overflow, plus the power-down and watchdog time-out bits. The flag operands the ALU consumes (carry for ADC, SBC and the through-carry rotates, and the half carry for decimal adjust) are read from that register, so the flags an operation produces feed the next one.

An operation commits its flags at the clock edge where `exec` is high. A data write to the status register (`stat_wr`) replaces only the four arithmetic flags. The power-down and time-out bits move only on the dedicated event inputs: watchdog clear, halt and watchdog time-out. A reset acts as the power-up event. All pins are plain control and data pins. The block has no streaming interface, so no valid/ready back-pressure applies: a new operation may be presented every cycle.

Top module: `alu8_flags`

## Requirements
- R1: `status_out` bit positions: carry C bit 0, half carry AC bit 1, zero Z bit 2, overflow OV bit 3, power-down PD bit 4, time-out TO bit 5; bits 6 and 7 always read 0.
- R2: Opcode values on `op`: ADD=0, ADC=1, SUB=2, SBC=3, DAA=4, AND=5, OR=6, XOR=7, CPL=8, RL=9, RR=10, RLC=11, RRC=12, INC=13, DEC=14, TSTZ=15. ADD/ADC give acc+opnd (+C for ADC), with C = carry out of bit 7 and AC = carry out of bit 3.
- R3: SUB gives acc-opnd and SBC gives acc-opnd-(1-C). C is 1 when no borrow occurs, and AC is 1 when the low nibble takes no borrow from the high nibble.
- R4: For the four add/subtract opcodes, OV is 1 exactly when the carry into bit 7 differs from the carry out of bit 7.
- R5: Arithmetic, logic (AND, OR, XOR, CPL = ~opnd), INC (opnd+1) and DEC (opnd-1) set Z exactly when the result is 0. Logic, INC and DEC change only Z.
- R6: RL/RR rotate `opnd` left/right with bit 7 wrapping to bit 0 (or bit 0 to bit 7) and leave all flags unchanged. RLC/RRC shift C into the vacated bit and load C with the bit shifted out.
- R7: DAA works on acc. It adds 0x06 when acc[3:0] > 9 or AC=1, adds 0x60 when acc > 0x99 or C=1, sets C to whether the 0x60 correction applied, updates Z, and leaves AC and OV unchanged.
- R8: `skip` is 1 exactly when the result is 0 for INC, DEC and TSTZ (result = opnd). It is 0 for every other opcode. TSTZ changes no flag.
- R9: A status write (`stat_wr`) loads `stat_wdata[3:0]` into the four arithmetic flags and takes precedence over `exec` in the same cycle. It never changes PD or TO.
- R10: The watchdog-clear event clears PD and TO. The halt event sets PD and clears TO. The time-out event sets TO. If events coincide, the priority is clear, then halt, then time-out.
- R11: Reset clears every status bit.
- R12: `result` and `skip` follow the inputs in the same cycle. Flags change only at a clock edge with `exec` or `stat_wr` high and are visible from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low (power-up) |
| op | input | 4 | Opcode |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Memory or immediate operand |
| exec | input | 1 | Commit this operation's flags at the edge |
| stat_wr | input | 1 | Data write of the status register |
| stat_wdata | input | 8 | Status write data (bits 3:0 used) |
| ev_wdt_clr | input | 1 | Watchdog-clear event |
| ev_halt | input | 1 | Halt event |
| ev_wdt_to | input | 1 | Watchdog time-out event |
| result | output | 8 | ALU result |
| skip | output | 1 | Skip condition |
| status_out | output | 8 | Status register |

## Verification
`result` and `skip` are due in the cycle the inputs are applied. The bench drives on the falling edge and compares them a nanosecond later, before the rising edge. Flag and PD/TO effects are due at the next rising edge. They are compared against the bench's model at the following falling edge, before any new stimulus is applied. The model advances its own status copy only at the rising edge, so every flag-dependent opcode uses the same flag state the design sees.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW  = 8;
  localparam int NW  = DW / 2;
  localparam int NFL = 4;
  localparam int FC  = 0;
  localparam int FAC = 1;
  localparam int FZ  = 2;
  localparam int FOV = 3;
  localparam int BPD = 4;
  localparam int BTO = 5;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_DAA  = 4'd4,  OP_AND = 4'd5,  OP_OR  = 4'd6,  OP_XOR = 4'd7,
    OP_CPL  = 4'd8,  OP_RL  = 4'd9,  OP_RR  = 4'd10, OP_RLC = 4'd11,
    OP_RRC  = 4'd12, OP_INC = 4'd13, OP_DEC = 4'd14, OP_TSTZ = 4'd15
  } alu_op_e;
endpackage

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  alu_op_e          op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  logic             c_in,
  input  logic             ac_in,
  output logic [DW-1:0]    res,
  output logic             skip,
  output logic [NFL-1:0]   nf,
  output logic [NFL-1:0]   mask
);
  logic            sub, ci, lo_fix, hi_fix;
  logic [DW-1:0]   bb;
  logic [DW:0]     s_full;
  logic [NW:0]     s_nib;
  logic [DW-1:0]   s_low7;

  always_comb begin
    sub    = (op == OP_SUB) || (op == OP_SBC);
    bb     = sub ? ~b : b;
    ci     = (op == OP_ADD) ? 1'b0 : (op == OP_SUB) ? 1'b1 : c_in;
    s_full = {1'b0, a} + {1'b0, bb} + {{DW{1'b0}}, ci};
    s_nib  = {1'b0, a[NW-1:0]} + {1'b0, bb[NW-1:0]} + {{NW{1'b0}}, ci};
    s_low7 = {1'b0, a[DW-2:0]} + {1'b0, bb[DW-2:0]} + {{(DW-1){1'b0}}, ci};
    lo_fix = (a[NW-1:0] > 4'd9) || ac_in;
    hi_fix = (a > 8'h99) || c_in;

    res  = '0;
    skip = 1'b0;
    nf   = '0;
    mask = '0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        res      = s_full[DW-1:0];
        nf[FC]   = s_full[DW];
        nf[FAC]  = s_nib[NW];
        nf[FOV]  = s_low7[DW-1] ^ s_full[DW];
        mask     = '1;
      end
      OP_DAA: begin
        res        = a + (lo_fix ? 8'h06 : 8'h00) + (hi_fix ? 8'h60 : 8'h00);
        nf[FC]     = hi_fix;
        mask[FC]   = 1'b1;
        mask[FZ]   = 1'b1;
      end
      OP_AND: begin res = a & b; mask[FZ] = 1'b1; end
      OP_OR:  begin res = a | b; mask[FZ] = 1'b1; end
      OP_XOR: begin res = a ^ b; mask[FZ] = 1'b1; end
      OP_CPL: begin res = ~b;    mask[FZ] = 1'b1; end
      OP_RL:  res = {b[DW-2:0], b[DW-1]};
      OP_RR:  res = {b[0], b[DW-1:1]};
      OP_RLC: begin
        res = {b[DW-2:0], c_in}; nf[FC] = b[DW-1]; mask[FC] = 1'b1;
      end
      OP_RRC: begin
        res = {c_in, b[DW-1:1]}; nf[FC] = b[0]; mask[FC] = 1'b1;
      end
      OP_INC: begin res = b + 8'd1; mask[FZ] = 1'b1; skip = (res == '0); end
      OP_DEC: begin res = b - 8'd1; mask[FZ] = 1'b1; skip = (res == '0); end
      OP_TSTZ: begin res = b; skip = (b == '0); end
      default: res = '0;
    endcase
    nf[FZ] = (res == '0);
  end

  // R8: a raised skip always comes with a zero result
  always_comb begin
    a_r8_skip_zero: assert (!skip || (res == '0));
  end
endmodule

// File: rtl/alu8_stat.sv
module alu8_stat
  import alu8_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NFL-1:0]  wr_val,
  input  logic            upd_en,
  input  logic [NFL-1:0]  upd_mask,
  input  logic [NFL-1:0]  upd_val,
  input  logic            ev_clr,
  input  logic            ev_halt,
  input  logic            ev_to,
  output logic [NFL-1:0]  fl,
  output logic            pd,
  output logic            to
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl <= '0;
      pd <= 1'b0;
      to <= 1'b0;
    end else begin
      if (wr_en)       fl <= wr_val;
      else if (upd_en) fl <= (fl & ~upd_mask) | (upd_val & upd_mask);
      if (ev_clr) begin
        pd <= 1'b0;
        to <= 1'b0;
      end else if (ev_halt) begin
        pd <= 1'b1;
        to <= 1'b0;
      end else if (ev_to) begin
        to <= 1'b1;
      end
    end
  end

  a_r9_write_keeps_pd_to: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ev_clr && !ev_halt && !ev_to) |=> (pd == $past(pd)) && (to == $past(to)));

  a_r9_write_loads_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> fl == $past(wr_val));

  a_r10_clear_event: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clr |=> !pd && !to);

  a_r10_halt_event: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_halt && !ev_clr) |=> pd && !to);

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !upd_en) |=> $stable(fl));
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op,
  input  logic [7:0]   acc_in,
  input  logic [7:0]   opnd_in,
  input  logic         exec,
  input  logic         stat_wr,
  input  logic [7:0]   stat_wdata,
  input  logic         ev_wdt_clr,
  input  logic         ev_halt,
  input  logic         ev_wdt_to,
  output logic [7:0]   result,
  output logic         skip,
  output logic [7:0]   status_out
);
  logic [NFL-1:0] fl, nf, mask;
  logic           pd, to;
  alu_op_e        op_e;

  assign op_e = alu_op_e'(op);

  alu8_core u_core (
    .op    (op_e),
    .a     (acc_in),
    .b     (opnd_in),
    .c_in  (fl[FC]),
    .ac_in (fl[FAC]),
    .res   (result),
    .skip  (skip),
    .nf    (nf),
    .mask  (mask)
  );

  alu8_stat u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (stat_wr),
    .wr_val   (stat_wdata[NFL-1:0]),
    .upd_en   (exec),
    .upd_mask (mask),
    .upd_val  (nf),
    .ev_clr   (ev_wdt_clr),
    .ev_halt  (ev_halt),
    .ev_to    (ev_wdt_to),
    .fl       (fl),
    .pd       (pd),
    .to       (to)
  );

  assign status_out = {2'b00, to, pd, fl};

  a_r6_plain_rotate_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !stat_wr && (op_e == OP_RL || op_e == OP_RR)) |=> status_out[FC] == $past(status_out[FC]));

  a_r5_logic_sets_z: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !stat_wr && (op_e == OP_AND || op_e == OP_XOR)) |=> status_out[FZ] == ($past(result) == 8'h00));

  a_r8_test_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !stat_wr && op_e == OP_TSTZ) |=> status_out[3:0] == $past(status_out[3:0]));
endmodule

// File: tb/alu8_flags_bench.sv
module alu8_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] acc_in = '0, opnd_in = '0, stat_wdata = '0;
  logic       exec = 1'b0, stat_wr = 1'b0;
  logic       ev_wdt_clr = 1'b0, ev_halt = 1'b0, ev_wdt_to = 1'b0;
  logic [7:0] result, status_out;
  logic       skip;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int m_c = 0, m_ac = 0, m_z = 0, m_ov = 0, m_pd = 0, m_to = 0;
  string last_req = "R11";

  always #2.5 clk = ~clk;

  alu8_flags u_alu8_flags (
    .clk(clk), .rst_n(rst_n), .op(op), .acc_in(acc_in), .opnd_in(opnd_in),
    .exec(exec), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .ev_wdt_clr(ev_wdt_clr), .ev_halt(ev_halt), .ev_wdt_to(ev_wdt_to),
    .result(result), .skip(skip), .status_out(status_out)
  );

  function automatic string req_of(int o);
    case (o)
      0, 1: return "R2";
      2, 3: return "R3";
      4: return "R7";
      5, 6, 7, 8, 13, 14: return "R5";
      9, 10, 11, 12: return "R6";
      default: return "R8";
    endcase
  endfunction

  function automatic int model_status();
    return (m_to << 5) | (m_pd << 4) | (m_ov << 3) | (m_z << 2) | (m_ac << 1) | m_c;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: check previous status, drive, check comb outputs, advance model
  task automatic step(int o, int a, int b, bit ex, bit wr = 0, int wd = 0,
                      bit clr = 0, bit hlt = 0, bit tmo = 0);
    int res, sk, nc, nac, nz, nov, bb, ci, s;
    bit upd_c, upd_ac, upd_z, upd_ov;
    @(negedge clk);
    check(last_req, status_out, model_status(), "status");
    op = o[3:0]; acc_in = a[7:0]; opnd_in = b[7:0]; exec = ex;
    stat_wr = wr; stat_wdata = wd[7:0];
    ev_wdt_clr = clr; ev_halt = hlt; ev_wdt_to = tmo;
    res = 0; sk = 0; nc = m_c; nac = m_ac; nov = m_ov;
    upd_c = 0; upd_ac = 0; upd_z = 0; upd_ov = 0;
    case (o)
      0, 1, 2, 3: begin
        bb = (o >= 2) ? (255 - b) : b;
        ci = (o == 0) ? 0 : (o == 2) ? 1 : m_c;
        s = a + bb + ci;
        res = s % 256;
        nc = s / 256;
        nac = (((a % 16) + (bb % 16) + ci) > 15) ? 1 : 0;
        nov = ((((a % 128) + (bb % 128) + ci) > 127) ? 1 : 0) ^ nc;
        upd_c = 1; upd_ac = 1; upd_z = 1; upd_ov = 1;
      end
      4: begin
        s = a;
        if ((a % 16) > 9 || m_ac == 1) s += 6;
        nc = (a > 153 || m_c == 1) ? 1 : 0;
        if (nc == 1) s += 96;
        res = s % 256; upd_c = 1; upd_z = 1;
      end
      5: begin res = a & b; upd_z = 1; end
      6: begin res = a | b; upd_z = 1; end
      7: begin res = a ^ b; upd_z = 1; end
      8: begin res = 255 - b; upd_z = 1; end
      9: res = (b * 2) % 256 + b / 128;
      10: res = b / 2 + (b % 2) * 128;
      11: begin res = (b * 2) % 256 + m_c; nc = b / 128; upd_c = 1; end
      12: begin res = b / 2 + m_c * 128; nc = b % 2; upd_c = 1; end
      13: begin res = (b + 1) % 256; upd_z = 1; sk = (res == 0); end
      14: begin res = (b + 255) % 256; upd_z = 1; sk = (res == 0); end
      default: begin res = b; sk = (b == 0); end
    endcase
    nz = (res == 0) ? 1 : 0;
    #1;
    check(req_of(o), result, res, "result");
    check((o >= 13) ? "R8" : "R8/other", skip, sk, "skip");
    @(posedge clk);
    if (wr) begin
      m_c = wd % 2; m_ac = (wd / 2) % 2; m_z = (wd / 4) % 2; m_ov = (wd / 8) % 2;
    end else if (ex) begin
      if (upd_c) m_c = nc;
      if (upd_ac) m_ac = nac;
      if (upd_z) m_z = nz;
      if (upd_ov) m_ov = nov;
    end
    if (clr) begin m_pd = 0; m_to = 0; end
    else if (hlt) begin m_pd = 1; m_to = 0; end
    else if (tmo) m_to = 1;
    last_req = wr ? "R9" : (clr || hlt || tmo) ? "R10" : ex ? req_of(o) : "R12";
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", status_out, 0, "status after reset");
    check("R1", status_out[7:6], 0, "unused bits");
    rst_n = 1'b1;
    // R2 add, half carry and carry
    step(0, 8'h0F, 8'h01, 1);
    step(0, 8'hFF, 8'h01, 1);
    step(1, 8'h10, 8'h10, 1);          // ADC with C=1
    // R4 overflow
    step(0, 8'h7F, 8'h01, 1);
    step(0, 8'h80, 8'h80, 1);
    // R3 subtraction, no-borrow carry
    step(2, 8'h05, 8'h03, 1);
    step(2, 8'h03, 8'h05, 1);
    step(3, 8'h10, 8'h01, 1);          // SBC with C=0
    step(2, 8'h10, 8'h01, 1);          // low nibble borrows
    // R7 decimal adjust
    step(0, 8'h09, 8'h08, 1);          // AC set
    step(4, 8'h11, 8'h00, 1);
    step(4, 8'h9A, 8'h00, 1);
    step(4, 8'h45, 8'h00, 1);
    // R5 logic/inc/dec
    step(5, 8'hF0, 8'h0F, 1);
    step(8, 8'h00, 8'hFF, 1);
    // R6 rotates
    step(9, 8'h00, 8'h81, 1);
    step(11, 8'h00, 8'h81, 1);
    step(12, 8'h00, 8'h02, 1);
    step(10, 8'h00, 8'h01, 1);
    // R8 skip
    step(13, 8'h00, 8'hFF, 1);
    step(14, 8'h00, 8'h01, 1);
    step(15, 8'h00, 8'h00, 1);
    step(15, 8'h00, 8'h07, 1);
    // R9 status write with exec, and PD/TO bits in data
    step(0, 8'hFF, 8'hFF, 1, 1, 8'hF5);
    step(0, 8'h01, 8'h01, 0, 1, 8'h3A);
    // R10 events and priority
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1, 8'h30, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 1, 1, 1);
    // R12 no exec holds flags
    step(2, 8'h00, 8'h01, 0);
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 31);
      step($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255),
           (r != 0), (r == 1), $urandom_range(0, 255), (r == 2), (r == 3), (r == 4));
    end
    @(negedge clk);
    check(last_req, status_out, model_status(), "status");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule